// File: doc/BRIEF.md
# Legacy Upper-Memory Shadow Router

This block belongs in a host bridge. It watches every memory access that falls in the legacy upper area below 1 MB, from 0x000C0000 to 0x000FFFFF. For each access it decides whether system DRAM serves it or whether it is passed on to the PCI bus. A small bank of byte-wide configuration registers holds a 2-bit attribute for each segment of that area. The attribute controls reads and writes separately, so a read and a write to the same address can go to different targets. One use is to copy a boot ROM into DRAM: reads still come from the ROM on PCI while the writes fill the DRAM below it.

The area is split into thirteen segments. Twelve of them are 16 KB segments covering 0xC0000–0xEFFFF. The thirteenth is a single 64 KB segment covering 0xF0000–0xFFFFF. Seven configuration registers start at a byte offset set by a parameter. The default placement is 0x59–0x5F, and 0x90–0x96 is reached by changing that parameter. Configuration reads and the route decision are both combinational. Only configuration writes are clocked.

Top module: `shadow_route`

## Requirements
- R1: After reset every attribute register reads 0x00. Every access inside the window, whether a read or a write, routes to PCI (`route_pci`=1).
- R2: An access outside 0x000C0000–0x000FFFFF routes to DRAM (`route_pci`=0) whatever the register contents. This includes addresses at or above 1 MB whose low 20 bits alias into the window.
- R3: The attribute encoding is 00 disabled, 01 read-only, 10 write-only and 11 read-write. A read goes to DRAM only when bit 0 of the field is 1, and a write goes to DRAM only when bit 1 is 1. Every other access inside the window goes to PCI.
- R4: Field placement is as follows.
  - Register at offset BANK_BASE+0 holds the 64 KB segment 0xF0000–0xFFFFF in bits [5:4].
  - Register at offset BANK_BASE+1+j (j = 0..5) holds two 16 KB segments. Bits [1:0] cover 0xC0000+0x8000·j. Bits [5:4] cover 0xC4000+0x8000·j.
- R5: Unused bits are stored as zero and always read back as zero. These are bits [7:6], [3:0] of register 0 and bits [7:6], [3:2] of the others. A configuration read at any offset outside the bank returns 0x00, and a write there changes no route and no register.
- R6: A configuration write is stored at the rising clock edge where `cfg_we` is high. Before that edge the old value is still visible on `cfg_rdata` and in the route. From that edge on, the new value is visible on both.
- R7: With BANK_BASE = 0x90 the bank answers at offsets 0x90–0x96 with the same layout. Offsets 0x59–0x5F then lie outside the bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for configuration writes |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_addr | input | CFG_AW | Configuration byte offset |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_rdata | output | 8 | Configuration read data for cfg_addr (combinational) |
| acc_addr | input | ADDR_W | Memory access address |
| acc_write | input | 1 | Access direction: 1 write, 0 read |
| route_pci | output | 1 | 1 sends the access to PCI, 0 to DRAM (combinational) |

## Verification
The route and the configuration read data are due in the same cycle as the address and direction that produce them. The bench therefore drives these inputs on the falling edge and samples 2 ns later, before any rising edge. A configuration write is due one rising edge after the strobe. The bench checks the old value just after it raises the strobe. It checks the new value on the following falling edge, once the single register stage has loaded. Two instances, one at each bank placement, share the inputs. This shows in the same cycles that each instance ignores the other's offsets.

// File: rtl/shadow_pkg.sv
// Package shadow_pkg
// Shared constants, attribute encoding and layout helpers for the
// legacy upper-memory shadow router. Assumes the fixed window
// 0xC0000-0xFFFFF: twelve 16 KB segments plus one 64 KB top segment.
package shadow_pkg;

    localparam int NUM_REGS = 7;
    localparam int NUM_SEGS = 13;
    localparam int SEG_W    = $clog2(NUM_SEGS);
    localparam int TOP_SEG  = NUM_SEGS - 1;

    typedef enum logic [1:0] {
        ATTR_OFF = 2'b00,
        ATTR_RO  = 2'b01,
        ATTR_WO  = 2'b10,
        ATTR_RW  = 2'b11
    } attr_e;

    // Implemented bits of register idx within the bank.
    function automatic logic [7:0] reg_mask(input int idx);
        return (idx == 0) ? 8'h30 : 8'h33;
    endfunction

endpackage

// File: rtl/shadow_cfg_bank.sv
// Module shadow_cfg_bank
// Holds the seven attribute registers at byte offsets BANK_BASE..+6.
// Writes are clocked. Reads and the per-segment attribute outputs are
// combinational. Assumes BANK_BASE+6 fits in CFG_AW bits.
module shadow_cfg_bank
    import shadow_pkg::*;
#(
    parameter int CFG_AW    = 8,
    parameter int BANK_BASE = 'h59
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [CFG_AW-1:0]             cfg_addr,
    input  logic [7:0]                    cfg_wdata,
    input  logic                          cfg_we,
    output logic [7:0]                    cfg_rdata,
    output logic [NUM_SEGS-1:0][1:0]      seg_attr
);

    logic [NUM_REGS-1:0][7:0] bank_q;
    logic [NUM_REGS-1:0]      hit;

    for (genvar k = 0; k < NUM_REGS; k++) begin : g_reg
        localparam logic [CFG_AW-1:0] OFFS = CFG_AW'(BANK_BASE + k);
        localparam logic [7:0]        MASK = reg_mask(k);

        // Decode whether cfg_addr selects this register.
        assign hit[k] = (cfg_addr == OFFS);

        // Store masked write data; clear on reset.
        always_ff @(posedge clk) begin
            if (!rst_n)
                bank_q[k] <= 8'h00;
            else if (cfg_we && hit[k])
                bank_q[k] <= cfg_wdata & MASK;
        end
    end

    // Return the selected register, or zero off the bank.
    always_comb begin
        cfg_rdata = 8'h00;
        for (int k = 0; k < NUM_REGS; k++)
            if (hit[k]) cfg_rdata = bank_q[k];
    end

    // Spread the register fields into one attribute per segment.
    for (genvar s = 0; s < TOP_SEG; s++) begin : g_seg
        localparam int RIDX = 1 + s / 2;
        localparam int LSB  = (s % 2) * 4;
        assign seg_attr[s] = bank_q[RIDX][LSB +: 2];
    end
    assign seg_attr[TOP_SEG] = bank_q[0][5:4];

endmodule

// File: rtl/shadow_seg_decode.sv
// Module shadow_seg_decode
// Decides whether an address lies in 0xC0000-0xFFFFF and, if so,
// which segment it hits (0..11 for 16 KB segments, 12 for 0xF0000).
// Assumes ADDR_W > 20.
module shadow_seg_decode
    import shadow_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              in_win,
    output logic [SEG_W-1:0]  seg_idx
);

    localparam int HI_W = ADDR_W - 20;

    // Window test: no bits at or above 1 MB, and the top quarter of it.
    assign in_win = (addr[ADDR_W-1:20] == HI_W'(0)) && (addr[19:18] == 2'b11);

    // Segment select: the top 64 KB is one segment, the rest is 16 KB each.
    always_comb begin
        if (addr[17:16] == 2'b11)
            seg_idx = SEG_W'(TOP_SEG);
        else
            seg_idx = SEG_W'(addr[17:14]);
    end

endmodule

// File: rtl/shadow_route.sv
// Module shadow_route (top)
// Routes legacy upper-memory accesses to DRAM or PCI according to a
// per-segment, per-direction attribute held in a configuration bank.
// The route is combinational from the access and the stored attributes.
module shadow_route
    import shadow_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int CFG_AW    = 8,
    parameter int BANK_BASE = 'h59
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [7:0]        cfg_wdata,
    input  logic              cfg_we,
    output logic [7:0]        cfg_rdata,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              acc_write,
    output logic              route_pci
);

    logic [NUM_SEGS-1:0][1:0] seg_attr;
    logic                     in_win;
    logic [SEG_W-1:0]         seg_idx;
    logic [1:0]               cur_attr;
    logic                     dir_ok;

    shadow_cfg_bank #(
        .CFG_AW   (CFG_AW),
        .BANK_BASE(BANK_BASE)
    ) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_addr (cfg_addr),
        .cfg_wdata(cfg_wdata),
        .cfg_we   (cfg_we),
        .cfg_rdata(cfg_rdata),
        .seg_attr (seg_attr)
    );

    shadow_seg_decode #(
        .ADDR_W(ADDR_W)
    ) u_dec (
        .addr   (acc_addr),
        .in_win (in_win),
        .seg_idx(seg_idx)
    );

    // Pick the attribute of the segment being accessed.
    always_comb begin
        cur_attr = ATTR_OFF;
        for (int s = 0; s < NUM_SEGS; s++)
            if (seg_idx == SEG_W'(s)) cur_attr = seg_attr[s];
    end

    // Bit 0 enables reads, bit 1 enables writes.
    assign dir_ok = acc_write ? cur_attr[1] : cur_attr[0];

    // Inside the window, any access whose direction is not enabled goes to PCI.
    assign route_pci = in_win && !dir_ok;

endmodule

// File: rtl/shadow_route_chk.sv
// Module shadow_route_chk
// Port-level checker for shadow_route, attached by bind below.
// Assumes the window and bank layout given in the requirements.
module shadow_route_chk #(
    parameter int ADDR_W    = 32,
    parameter int CFG_AW    = 8,
    parameter int BANK_BASE = 'h59
) (
    input logic              clk,
    input logic              rst_n,
    input logic [CFG_AW-1:0] cfg_addr,
    input logic [7:0]        cfg_wdata,
    input logic              cfg_we,
    input logic [7:0]        cfg_rdata,
    input logic [ADDR_W-1:0] acc_addr,
    input logic              acc_write,
    input logic              route_pci
);

    logic              outside;
    logic [CFG_AW-1:0] rel_off;
    logic              in_bank;
    logic [7:0]        cur_mask;

    // Window computed arithmetically from the address.
    assign outside  = (acc_addr < ADDR_W'('h000C0000)) || (acc_addr > ADDR_W'('h000FFFFF));
    assign rel_off  = cfg_addr - CFG_AW'(BANK_BASE);
    assign in_bank  = (cfg_addr >= CFG_AW'(BANK_BASE)) && (rel_off < CFG_AW'(7));
    assign cur_mask = (rel_off == '0) ? 8'h30 : 8'h33;

    AST_OUTSIDE_DRAM: assert property (@(posedge clk) disable iff (!rst_n)
        outside |-> !route_pci); // R2

    AST_OFFBANK_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !in_bank |-> (cfg_rdata == 8'h00)); // R5

    AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        in_bank |-> ((cfg_rdata & ~cur_mask) == 8'h00)); // R5

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && in_bank) |=>
            ((cfg_addr != $past(cfg_addr)) || (cfg_rdata == ($past(cfg_wdata) & cur_mask)))); // R6

endmodule

bind shadow_route shadow_route_chk #(
    .ADDR_W   (ADDR_W),
    .CFG_AW   (CFG_AW),
    .BANK_BASE(BANK_BASE)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_addr (cfg_addr),
    .cfg_wdata(cfg_wdata),
    .cfg_we   (cfg_we),
    .cfg_rdata(cfg_rdata),
    .acc_addr (acc_addr),
    .acc_write(acc_write),
    .route_pci(route_pci)
);

// File: tb/sim_shadow_route.sv
// Bench for shadow_route: two instances (bank at 0x59 and at 0x90)
// share all inputs; expected values come from an arithmetic model.
module sim_shadow_route;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  cfg_addr = 8'h00;
    logic [7:0]  cfg_wdata = 8'h00;
    logic        cfg_we = 1'b0;
    logic [31:0] acc_addr = 32'h0;
    logic        acc_write = 1'b0;
    logic [7:0]  rdata0, rdata1;
    logic        pci0, pci1;

    int checks = 0;
    int errors = 0;
    logic [7:0] model0 [7];
    logic [7:0] model1 [7];

    always #10 clk = ~clk;

    shadow_route #(.ADDR_W(32), .CFG_AW(8), .BANK_BASE('h59)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .cfg_we(cfg_we), .cfg_rdata(rdata0), .acc_addr(acc_addr),
        .acc_write(acc_write), .route_pci(pci0));

    shadow_route #(.ADDR_W(32), .CFG_AW(8), .BANK_BASE('h90)) u1 (
        .clk(clk), .rst_n(rst_n), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .cfg_we(cfg_we), .cfg_rdata(rdata1), .acc_addr(acc_addr),
        .acc_write(acc_write), .route_pci(pci1));

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h (cfg %h acc %h w %b)",
                     req, act, exp, cfg_addr, acc_addr, acc_write);
        end
    endtask

    function automatic logic [7:0] mask_of(input int idx);
        return (idx == 0) ? 8'h30 : 8'h33;
    endfunction

    // Expected register read for a bank at base.
    function automatic logic [7:0] exp_read(input int base, input int off, input bit which);
        if (off < base || off > base + 6) return 8'h00;
        return which ? model1[off - base] : model0[off - base];
    endfunction

    // Expected route per R2/R3/R4.
    function automatic logic exp_route(input logic [31:0] a, input logic w, input bit which);
        logic [7:0] r;
        logic [1:0] f;
        int seg;
        if (a < 32'hC0000 || a > 32'hFFFFF) return 1'b0;
        if (a >= 32'hF0000) begin
            r = which ? model1[0] : model0[0];
            f = r[5:4];
        end else begin
            seg = int'((a - 32'hC0000) >> 14);
            r = which ? model1[1 + seg / 2] : model0[1 + seg / 2];
            f = (seg % 2 == 0) ? r[1:0] : r[5:4];
        end
        return w ? !f[1] : !f[0];
    endfunction

    // One configuration write; R6 old/new visibility checked around the edge.
    task automatic cfg_write(input logic [7:0] off, input logic [7:0] data);
        @(negedge clk);
        cfg_addr = off; cfg_wdata = data; cfg_we = 1'b1;
        #1;
        check("R6 old value before edge u0", rdata0, exp_read('h59, off, 0));
        check("R6 old value before edge u1", rdata1, exp_read('h90, off, 1));
        if (off >= 8'h59 && off <= 8'h5F) model0[off - 8'h59] = data & mask_of(off - 8'h59);
        if (off >= 8'h90 && off <= 8'h96) model1[off - 8'h90] = data & mask_of(off - 8'h90);
        @(negedge clk);
        cfg_we = 1'b0;
        #2;
        check("R6 new value after edge u0", rdata0, exp_read('h59, off, 0));
        check("R6 new value after edge u1", rdata1, exp_read('h90, off, 1));
    endtask

    task automatic probe(input logic [31:0] a, input logic w, input string req);
        acc_addr = a; acc_write = w;
        #2;
        check({req, " u0"}, 32'(pci0), 32'(exp_route(a, w, 0)));
        check({req, " u1"}, 32'(pci1), 32'(exp_route(a, w, 1)));
    endtask

    // Three addresses per segment, both directions.
    task automatic sweep_window(input string req);
        for (int s = 0; s < 13; s++) begin
            logic [31:0] st, ln;
            st = (s < 12) ? 32'hC0000 + 32'(s) * 32'h4000 : 32'hF0000;
            ln = (s < 12) ? 32'h4000 : 32'h10000;
            for (int d = 0; d < 2; d++) begin
                probe(st, d[0], req);
                probe(st + ln / 2 + 32'h5, d[0], req);
                probe(st + ln - 1, d[0], req);
            end
        end
    endtask

    task automatic sweep_outside(input string req);
        logic [31:0] outs [6];
        outs = '{32'h0, 32'hBFFFF, 32'h100000, 32'h1C0000, 32'hFFFFFFFF, 32'h000FC000 + 32'h100000};
        for (int i = 0; i < 6; i++)
            for (int d = 0; d < 2; d++) probe(outs[i], d[0], req);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        for (int k = 0; k < 7; k++) begin model0[k] = 8'h00; model1[k] = 8'h00; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #2;
        // R1: all registers zero, whole window to PCI.
        for (int k = 0; k < 7; k++) begin
            cfg_addr = 8'(8'h59 + k); #1; check("R1 reset reg u0", rdata0, 8'h00);
            cfg_addr = 8'(8'h90 + k); #1; check("R1 reset reg u1", rdata1, 8'h00);
        end
        sweep_window("R1 reset route");
        sweep_outside("R2 outside after reset");

        // R5: full offset sweep with all-ones writes; masks and off-bank zero.
        for (int o = 0; o < 256; o++) cfg_write(8'(o), 8'hFF);
        for (int o = 0; o < 256; o++) begin
            cfg_addr = 8'(o); #1;
            check("R5 readback u0", rdata0, exp_read('h59, o, 0));
            check("R5 readback u1", rdata1, exp_read('h90, o, 1));
        end
        sweep_window("R3 all read-write");
        sweep_outside("R2 outside all read-write");

        // R3: every attribute value in every field at once.
        for (int a = 0; a < 4; a++) begin
            for (int k = 0; k < 7; k++) begin
                cfg_write(8'(8'h59 + k), 8'(a * 8'h11));
                cfg_write(8'(8'h90 + k), 8'(a * 8'h11));
            end
            sweep_window("R3 uniform attribute");
            sweep_outside("R2 outside uniform");
        end

        // R4/R7: mixed patterns so each field differs from its neighbours.
        for (int v = 0; v < 12; v++) begin
            for (int k = 0; k < 7; k++) begin
                cfg_write(8'(8'h59 + k), 8'((v * 37 + k * 91 + 5) ^ (k * 6)));
                cfg_write(8'(8'h90 + k), 8'((v * 53 + k * 29 + 11)));
            end
            sweep_window("R4 R7 field placement");
        end

        // R5: writes off the bank change no route.
        for (int k = 0; k < 7; k++) cfg_write(8'(8'h59 + k), 8'h00);
        cfg_write(8'h58, 8'hFF);
        cfg_write(8'h60, 8'hFF);
        sweep_window("R5 off-bank write ignored");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule